// File: doc/BRIEF.md
# 5B/4B Receive Decoder with Delimiter Alignment

This block sits behind the descrambler of a 100 Mb/s receive path. It takes one serial bit per clock, with each 5-bit code-group arriving most significant bit first. It looks at every bit offset for a start-of-stream delimiter, and it accepts that delimiter only when an idle code-group comes directly before it. The bit phase found at the delimiter then fixes the code-group boundaries until the packet ends. During the packet, each code-group becomes one 4-bit nibble on a media-independent-style receive interface. The nibble comes with a one-cycle strobe, a data-valid level and an error flag.

The two delimiter code-groups come out as two preamble nibbles. Every later code-group is decoded with the standard 4B/5B data table. The output runs one code-group behind the input, so the block can see both code-groups of an end-of-stream pair before it commits a nibble. A packet ends cleanly on the end-of-stream pair. A packet that ends on two idles is marked as a premature end.

The controller has two states. HUNT compares a 15-bit window against idle, J, K at every bit. FRAME counts bit phase and acts once per code-group. There are four transitions:
- HUNT→FRAME on a start match (START).
- FRAME→HUNT on the end-of-stream pair (END_CLEAN).
- FRAME→HUNT on two idles (END_ABORT).
- Both states hold in every other cycle.

Top module: `r4b_rx_decode`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, rx_dv, nib_stb and rx_er are all low.
- R2: A packet starts only when the last 15 bits received are IDLE=11111, J=11000, K=10001, in that order and at any bit offset. A J/K pair whose previous code-group is not an idle starts nothing, and rx_dv stays low.
- R3: On a start, the registered outputs updated by the clock edge that samples the last bit of K show nib_stb=1, rx_dv=1, rx_nibble=0101 and rx_er=0. Five cycles later a second 0101 nibble is strobed.
- R4: The code-group phase is fixed at the start for the whole packet. nib_stb pulses for one cycle exactly every five cycles while rx_dv is high, and never while rx_dv is low.
- R5: Each code-group is strobed five cycles after its own last bit, using this table: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. rx_er is 0 for these nibbles.
- R6: Inside a packet, a code-group that is not in the data table is strobed with rx_nibble=0000 and rx_er=1. This covers J, K, R, a T not followed by R, a lone IDLE and unassigned codes.
- R7: A packet ends cleanly when T=01101 is followed by R=00111. Neither code-group produces a nibble. rx_dv falls at the edge that samples the last bit of R, with no strobe in that cycle.
- R8: When two IDLE code-groups follow each other inside a packet, the first one is strobed as the final nibble with rx_nibble=0000 and rx_er=1. rx_dv falls one cycle later.
- R9: After either kind of end, the start search resumes at once, so an IDLE, J, K right after the end starts a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Descrambled serial bit, code-group MSB first |
| rx_dv | output | 1 | Receive data valid, high for the packet |
| rx_nibble | output | 4 | Decoded nibble, valid with nib_stb |
| rx_er | output | 1 | Receive error for the strobed nibble |
| nib_stb | output | 1 | One-cycle pulse per nibble |

## Verification
On every cycle, assertions check that the strobe never appears without rx_dv, that strobes are at least five cycles apart, and that rx_er is only raised inside a packet. They also check that each rising rx_dv carries a preamble nibble and that rx_dv never falls together with a strobe. Other behaviours depend on the actual bit stream, and only the bench scenarios can show them:
- the exact cycle of each nibble and its decoded value
- the rejection of a J/K pair with no idle before it
- the handling of stray control code-groups in the middle of a packet
- alignment at a shifted bit phase
- the restart of the search right after a packet ends

// File: rtl/r4b_pkg.sv
package r4b_pkg;
    localparam int CG_W  = 5;
    localparam int NIB_W = 4;
    localparam int WIN_W = 3 * CG_W;
    localparam int PH_W  = $clog2(CG_W);

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;

    localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_BAD = 4'b0000;

    typedef enum logic {
        ST_HUNT,
        ST_FRAME
    } rx_state_e;

    typedef struct packed {
        logic             ok;
        logic [NIB_W-1:0] nib;
    } cg_dec_t;
endpackage

// File: rtl/r4b_shifter.sv
module r4b_shifter #(
    parameter int WIDTH = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [WIDTH-1:0] win
);
    logic [WIDTH-2:0] hist_q;

    // window includes the bit being sampled at this edge
    assign win = {hist_q, bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= win[WIDTH-2:0];
        end
    end
endmodule

// File: rtl/r4b_cg_decode.sv
module r4b_cg_decode
    import r4b_pkg::*;
(
    input  logic [CG_W-1:0] code,
    output cg_dec_t         dec
);
    always_comb begin
        dec = '{ok: 1'b1, nib: NIB_BAD};
        case (code)
            5'b11110: dec.nib = 4'h0;
            5'b01001: dec.nib = 4'h1;
            5'b10100: dec.nib = 4'h2;
            5'b10101: dec.nib = 4'h3;
            5'b01010: dec.nib = 4'h4;
            5'b01011: dec.nib = 4'h5;
            5'b01110: dec.nib = 4'h6;
            5'b01111: dec.nib = 4'h7;
            5'b10010: dec.nib = 4'h8;
            5'b10011: dec.nib = 4'h9;
            5'b10110: dec.nib = 4'hA;
            5'b10111: dec.nib = 4'hB;
            5'b11010: dec.nib = 4'hC;
            5'b11011: dec.nib = 4'hD;
            5'b11100: dec.nib = 4'hE;
            5'b11101: dec.nib = 4'hF;
            default:  dec = '{ok: 1'b0, nib: NIB_BAD};
        endcase
    end
endmodule

// File: rtl/r4b_rx_decode.sv
module r4b_rx_decode
    import r4b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    output logic             rx_dv,
    output logic [NIB_W-1:0] rx_nibble,
    output logic             rx_er,
    output logic             nib_stb
);
    logic [WIN_W-1:0] win;
    logic [CG_W-1:0]  prev_cg;
    logic [CG_W-1:0]  cur_cg;
    cg_dec_t          prev_dec;

    rx_state_e        state_q, state_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic             pre_q, pre_d;

    logic sof_hit, at_bound, end_clean, end_abort;

    r4b_shifter #(.WIDTH(WIN_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (rx_bit),
        .win    (win)
    );

    assign prev_cg = win[2*CG_W-1:CG_W];
    assign cur_cg  = win[CG_W-1:0];

    r4b_cg_decode u_dec (
        .code (prev_cg),
        .dec  (prev_dec)
    );

    assign sof_hit   = (win == {CG_IDLE, CG_J, CG_K});
    assign at_bound  = (state_q == ST_FRAME) && (ph_q == PH_W'(CG_W - 1));
    assign end_clean = at_bound && !pre_q && (prev_cg == CG_T) && (cur_cg == CG_R);
    assign end_abort = at_bound && !pre_q && (prev_cg == CG_IDLE) && (cur_cg == CG_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        pre_d   = pre_q;
        unique case (state_q)
            ST_HUNT: begin
                if (sof_hit) begin
                    state_d = ST_FRAME;
                    ph_d    = '0;
                    pre_d   = 1'b1;
                end
            end
            ST_FRAME: begin
                if (at_bound) begin
                    ph_d  = '0;
                    pre_d = 1'b0;
                end else begin
                    ph_d = ph_q + 1'b1;
                end
                if (end_clean || end_abort) begin
                    state_d = ST_HUNT;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            ph_q    <= '0;
            pre_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            pre_q   <= pre_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_dv     <= 1'b0;
            rx_nibble <= '0;
            rx_er     <= 1'b0;
            nib_stb   <= 1'b0;
        end else begin
            nib_stb <= 1'b0;
            unique case (state_q)
                ST_HUNT: begin
                    if (sof_hit) begin
                        nib_stb   <= 1'b1;
                        rx_dv     <= 1'b1;
                        rx_nibble <= NIB_PRE;
                        rx_er     <= 1'b0;
                    end else begin
                        rx_dv <= 1'b0;
                        rx_er <= 1'b0;
                    end
                end
                ST_FRAME: begin
                    if (at_bound) begin
                        if (pre_q) begin
                            nib_stb   <= 1'b1;
                            rx_nibble <= NIB_PRE;
                            rx_er     <= 1'b0;
                        end else if (end_clean) begin
                            rx_dv <= 1'b0;
                            rx_er <= 1'b0;
                        end else if (end_abort) begin
                            nib_stb   <= 1'b1;
                            rx_nibble <= NIB_BAD;
                            rx_er     <= 1'b1;
                        end else begin
                            nib_stb   <= 1'b1;
                            rx_nibble <= prev_dec.ok ? prev_dec.nib : NIB_BAD;
                            rx_er     <= !prev_dec.ok;
                        end
                    end
                end
            endcase
        end
    end

    AST_STB_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |-> rx_dv); // R4
    AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> !nib_stb ##1 !nib_stb ##1 !nib_stb ##1 !nib_stb); // R4
    AST_DV_RISE_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> (nib_stb && rx_nibble == NIB_PRE && !rx_er)); // R3
    AST_ER_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_dv); // R6
    AST_DV_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dv) |-> !nib_stb); // R7
endmodule

// File: tb/r4b_rx_decode_tb.sv
module r4b_rx_decode_tb;
    localparam int C_IDLE = 31, C_J = 24, C_K = 17, C_T = 13, C_R = 7;
    localparam int DCODE [16] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_dv, rx_er, nib_stb;
    logic [3:0] rx_nibble;

    int n_cmp = 0;
    int n_bad = 0;

    int sym_code[$];
    int sym_w[$];
    int bits[$];

    bit         e_stb[];
    bit         e_dv[];
    logic [3:0] e_nib[];
    bit         e_er[];
    string      e_tag[];

    always #10 clk = ~clk;

    r4b_rx_decode u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .rx_dv     (rx_dv),
        .rx_nibble (rx_nibble),
        .rx_er     (rx_er),
        .nib_stb   (nib_stb)
    );

    task automatic put(input int code, input int w);
        sym_code.push_back(code);
        sym_w.push_back(w);
        for (int i = w - 1; i >= 0; i--) bits.push_back((code >> i) & 1);
    endtask

    task automatic sym(input int code);
        put(code, 5);
    endtask

    task automatic syms(input int code, input int n);
        for (int i = 0; i < n; i++) put(code, 5);
    endtask

    task automatic dat(input int v);
        put(DCODE[v], 5);
    endtask

    function automatic bit is_s(input int k, input int code);
        return sym_w[k] == 5 && sym_code[k] == code;
    endfunction

    task automatic build_model;
        int nb;
        int ends[];
        int pos, restart, dv_start;
        bit hunt, pre;
        nb = bits.size();
        e_stb = new[nb]; e_dv = new[nb]; e_nib = new[nb]; e_er = new[nb]; e_tag = new[nb];
        ends = new[sym_code.size()];
        for (int i = 0; i < nb; i++) begin
            e_stb[i] = 0; e_dv[i] = 0; e_nib[i] = 0; e_er[i] = 0; e_tag[i] = "R4";
        end
        pos = 0;
        for (int k = 0; k < sym_code.size(); k++) begin
            ends[k] = pos + sym_w[k] - 1;
            pos += sym_w[k];
        end
        hunt = 1; pre = 0; restart = 0; dv_start = 0;
        for (int k = 0; k < sym_code.size(); k++) begin
            int c;
            c = ends[k];
            if (hunt) begin
                for (int b = c - sym_w[k] + 1; b <= c; b++) e_tag[b] = "R2";
                if (k - 2 >= restart && is_s(k-2, C_IDLE) && is_s(k-1, C_J) && is_s(k, C_K)) begin
                    hunt = 0; pre = 1; dv_start = c;
                    e_stb[c] = 1; e_nib[c] = 4'b0101; e_er[c] = 0;
                    e_tag[c] = (restart > 0) ? "R9" : "R3";
                end
            end else begin
                int pv, cv;
                pv = sym_code[k-1]; cv = sym_code[k];
                if (pre) begin
                    pre = 0;
                    e_stb[c] = 1; e_nib[c] = 4'b0101; e_tag[c] = "R3";
                end else if (pv == C_T && cv == C_R) begin
                    for (int b = dv_start; b < c; b++) e_dv[b] = 1;
                    e_tag[c] = "R7";
                    hunt = 1; restart = k;
                end else if (pv == C_IDLE && cv == C_IDLE) begin
                    for (int b = dv_start; b <= c; b++) e_dv[b] = 1;
                    e_stb[c] = 1; e_nib[c] = 0; e_er[c] = 1; e_tag[c] = "R8";
                    if (c + 1 < nb) e_tag[c+1] = "R8";
                    hunt = 1; restart = k;
                end else begin
                    bit ok;
                    ok = 0;
                    e_stb[c] = 1; e_nib[c] = 0;
                    for (int i = 0; i < 16; i++) begin
                        if (DCODE[i] == pv) begin
                            ok = 1; e_nib[c] = 4'(i);
                        end
                    end
                    e_er[c] = !ok;
                    e_tag[c] = ok ? "R5" : "R6";
                end
            end
        end
    endtask

    task automatic check_cycle(input int t);
        bit bad;
        n_cmp++;
        bad = (nib_stb !== e_stb[t]) || (rx_dv !== e_dv[t]);
        if (e_stb[t] && ((rx_nibble !== e_nib[t]) || (rx_er !== e_er[t]))) bad = 1;
        if (bad) begin
            n_bad++;
            $display("FAIL %s bit %0d: stb/dv/nib/er actual %b/%b/%h/%b expected %b/%b/%h/%b",
                     e_tag[t], t, nib_stb, rx_dv, rx_nibble, rx_er,
                     e_stb[t], e_dv[t], e_nib[t], e_er[t]);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // scenario A: clean packet carrying all sixteen data values (R3, R4, R5, R7)
        syms(C_IDLE, 4); sym(C_J); sym(C_K);
        for (int v = 0; v < 16; v++) dat(v);
        sym(C_T); sym(C_R); syms(C_IDLE, 3);
        // scenario B: shifted phase, unassigned code, end on idles (R4, R6, R8, R9)
        put(0, 3); syms(C_IDLE, 2); sym(C_J); sym(C_K);
        dat(5); dat(10); sym(0); dat(3); syms(C_IDLE, 2); syms(C_IDLE, 2);
        // scenario C: J/K after a data code-group must not start (R2)
        dat(4); sym(C_J); sym(C_K); dat(4); dat(2); syms(C_IDLE, 3);
        // scenario D: stray control codes inside a packet, then back-to-back restart (R6, R9)
        syms(C_IDLE, 2); sym(C_J); sym(C_K);
        dat(1); sym(C_IDLE); dat(2); sym(C_T); dat(3); sym(C_J); dat(4); sym(C_R);
        dat(5); sym(C_K); dat(6); sym(C_T); sym(C_R);
        sym(C_IDLE); sym(C_J); sym(C_K); dat(7); dat(8); sym(C_T); sym(C_R); syms(C_IDLE, 2);
        // scenario E: another bit phase (R4)
        put(0, 2); syms(C_IDLE, 3); sym(C_J); sym(C_K); dat(12); dat(9);
        sym(C_T); sym(C_R); syms(C_IDLE, 4);
        build_model();

        // R1: quiet outputs during and just after reset
        repeat (3) @(negedge clk);
        n_cmp++;
        if (rx_dv !== 0 || nib_stb !== 0 || rx_er !== 0) begin
            n_bad++;
            $display("FAIL R1 in reset: dv/stb/er actual %b/%b/%b expected 0/0/0", rx_dv, nib_stb, rx_er);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (rx_dv !== 0 || nib_stb !== 0 || rx_er !== 0) begin
            n_bad++;
            $display("FAIL R1 after reset: dv/stb/er actual %b/%b/%b expected 0/0/0", rx_dv, nib_stb, rx_er);
        end

        for (int t = 0; t <= bits.size(); t++) begin
            if (t > 0) check_cycle(t - 1);
            if (t < bits.size()) rx_bit = bits[t][0];
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule